// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared snooping bus. It uses four line states. Modified means the line is dirty and this cache holds the only copy. Exclusive means the line is clean and this cache holds the only copy. Shared means other caches may hold clean copies. Invalid means the line holds nothing. Each cache block is one data word.

The processor side takes one read or write at a time. The controller answers it once the target line is in a state that allows the access. When the access needs the bus, the controller raises a bus request that carries a command, an address and write-back data. The bus completes the transaction in the cycle in which the grant is high. Fill data and the wired-OR shared line are sampled in that same cycle.

The snoop side watches the transactions of other caches. In the cycle of a snoop it answers at once. It asserts its shared output for a read of a block it holds. It places dirty data on the flush port when another cache needs the latest copy. It then lowers the line state at the clock edge.

Top module: `mesi_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid, `cpu_req_ready` is high, and both `cpu_resp_valid` and `bus_req` are low. The first access to any address therefore misses.
- R2: A read miss issues a bus read (`bus_cmd` = 1) with the request address. If `shared_in` is low in the grant cycle the line becomes Exclusive. If it is high the line becomes Shared. The read returns the fill data.
- R3: A write to an Exclusive line completes with no bus transaction and leaves the line Modified.
- R4: A write to a Shared line, to an Invalid line, or to an address whose tag does not match issues a read-for-ownership (`bus_cmd` = 2) with the request address. The line then becomes Modified and holds the written word.
- R5: Reads that hit a line in M, E or S, and writes that hit a line in M, generate no bus transaction. Such a hit raises `cpu_resp_valid` on the second rising edge after the request is accepted.
- R6: `cpu_resp_valid` is a one-cycle pulse. A read returns the latest value written to that address anywhere in the system, and a write echoes its own data. `cpu_req_ready` is low from acceptance until the response.
- R7: In the cycle of a snooped bus read (`snp_cmd` = 1) that hits a valid line, `shared_out` is high. If the line is Modified, `flush_valid` is high and `flush_data` carries the line. The line then becomes Shared if it was M or E.
- R8: A snooped read-for-ownership (`snp_cmd` = 2) that hits a Modified line raises `flush_valid` with the line data. Any valid hit line becomes Invalid, and `shared_out` stays low.
- R9: A snoop whose tag does not match, or that finds the line Invalid, asserts neither `shared_out` nor `flush_valid` and changes no state.
- R10: A miss whose victim line is Modified first issues a write-back (`bus_cmd` = 3) carrying the victim's address, {victim tag, index}, and its data, and only then issues the read or read-for-ownership. A clean victim is replaced with no write-back. The line index is the low log2(LINES) address bits.
- R11: While `snp_valid` is high, `bus_req` is low and `bus_gnt` has no effect. The pending access resumes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_resp_valid | output | 1 | Response pulse |
| cpu_resp_rdata | output | DATA_W | Read data, or the written data for a write |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Transaction performed this cycle |
| bus_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data, valid in the grant cycle |
| shared_in | input | 1 | Wired-OR shared line, sampled on a bus read |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | 1 read, 2 read-for-ownership |
| snp_addr | input | ADDR_W | Snooped address |
| shared_out | output | 1 | Drive for the wired-OR shared line |
| flush_valid | output | 1 | Dirty data supplied this cycle |
| flush_data | output | DATA_W | Flushed line data |

## Verification
The bench uses the default build: 8 lines, 8-bit addresses and 32-bit words. This gives a 5-bit tag. Random addresses are drawn from four tags per index, so conflict evictions of dirty and clean victims, upgrades from Shared, and snoops that hit every state all occur often. A reference model of the line states and of memory predicts the exact sequence of bus commands for each access, as well as its response data. Directed cases cover the silent Exclusive upgrade, both values of the shared line, flushes on both snoop kinds, and a snoop arriving while a grant is offered.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_e;

    // Bus action the pending processor access needs, given the current line
    function automatic bus_cmd_e proc_action(input mesi_e st, input logic tag_eq,
                                             input logic is_wr);
        bus_cmd_e a;
        a = CMD_NONE;
        if (st == ST_M && !tag_eq)
            a = CMD_WB;
        else if (!(tag_eq && st != ST_I))
            a = is_wr ? CMD_RDX : CMD_RD;
        else if (is_wr && st == ST_S)
            a = CMD_RDX;
        return a;
    endfunction

    // State a line takes after its own fill completes
    function automatic mesi_e fill_state(input logic is_rdx, input logic shared);
        mesi_e s;
        if (is_rdx)      s = ST_M;
        else if (shared) s = ST_S;
        else             s = ST_E;
        return s;
    endfunction

    // State a hit line takes after another cache's transaction
    function automatic mesi_e snoop_state(input mesi_e cur, input logic is_rdx);
        mesi_e s;
        if (cur == ST_I || is_rdx) s = ST_I;
        else                       s = ST_S;
        return s;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  mesi_e             wr_state,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  a_idx,
    output mesi_e             a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output mesi_e             b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data
);

    mesi_e             st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]  <= ST_I;
                tag_q[g] <= '0;
                dat_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                st_q[g]  <= wr_state;
                tag_q[g] <= wr_tag;
                dat_q[g] <= wr_data;
            end
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = dat_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = dat_q[b_idx];

endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  line_idx,
    input  mesi_e             line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              shared_out,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data,
    output logic              upd_en,
    output mesi_e             upd_state
);

    logic is_rd, is_rdx, hit;

    assign line_idx = snp_addr[IDX_W-1:0];
    assign is_rd    = snp_cmd == CMD_RD;
    assign is_rdx   = snp_cmd == CMD_RDX;
    assign hit      = snp_valid && (is_rd || is_rdx) && line_state != ST_I
                      && line_tag == snp_addr[ADDR_W-1:IDX_W];

    always_comb begin
        shared_out  = hit && is_rd;
        flush_valid = hit && line_state == ST_M;
        flush_data  = flush_valid ? line_data : '0;
        upd_state   = snoop_state(line_state, is_rdx);
        upd_en      = hit && upd_state != line_state;
    end

endmodule

// File: rtl/mesi_req_seq.sv
module mesi_req_seq
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    input  logic              snoop_active,
    output logic [IDX_W-1:0]  line_idx,
    input  mesi_e             line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              shared_in,
    output logic              wr_en,
    output mesi_e             wr_state,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data
);

    logic              pend_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TAG_W-1:0]  req_tag;
    bus_cmd_e          act;
    logic              fire, done;

    assign line_idx = addr_q[IDX_W-1:0];
    assign req_tag  = addr_q[ADDR_W-1:IDX_W];

    // The needed action is recomputed every cycle from the live line state,
    // so a snoop that changes the line simply changes the next request.
    always_comb begin
        act       = pend_q ? proc_action(line_state, line_tag == req_tag, wr_q) : CMD_NONE;
        bus_req   = pend_q && act != CMD_NONE && !snoop_active;
        bus_cmd   = act;
        bus_addr  = (act == CMD_WB) ? {line_tag, line_idx} : addr_q;
        bus_wdata = line_data;
        fire      = bus_req && bus_gnt;
        done      = pend_q && act == CMD_NONE && !snoop_active;
    end

    always_comb begin
        wr_en    = 1'b0;
        wr_state = ST_I;
        wr_tag   = req_tag;
        wr_data  = line_data;
        if (fire) begin
            unique case (act)
                CMD_WB: begin
                    wr_en  = 1'b1;
                    wr_tag = line_tag;
                end
                CMD_RD, CMD_RDX: begin
                    wr_en    = 1'b1;
                    wr_state = fill_state(act == CMD_RDX, shared_in);
                    wr_data  = bus_rdata;
                end
                default: ;
            endcase
        end else if (done && wr_q) begin
            wr_en    = 1'b1;
            wr_state = ST_M;
            wr_data  = wdata_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q         <= 1'b0;
            wr_q           <= 1'b0;
            addr_q         <= '0;
            wdata_q        <= '0;
            cpu_resp_valid <= 1'b0;
            cpu_resp_rdata <= '0;
        end else begin
            cpu_resp_valid <= 1'b0;
            if (cpu_req_valid && !pend_q) begin
                pend_q  <= 1'b1;
                wr_q    <= cpu_req_write;
                addr_q  <= cpu_req_addr;
                wdata_q <= cpu_req_wdata;
            end
            if (done) begin
                pend_q         <= 1'b0;
                cpu_resp_valid <= 1'b1;
                cpu_resp_rdata <= wr_q ? wdata_q : line_data;
            end
        end
    end

    assign cpu_req_ready = !pend_q;

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              shared_out,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  rq_idx, sn_idx, st_idx;
    mesi_e             rq_state, sn_state, seq_wstate, sn_ustate, st_state;
    logic [TAG_W-1:0]  rq_tag, sn_tag, seq_wtag, st_tag;
    logic [DATA_W-1:0] rq_data, sn_data, seq_wdata, st_data;
    logic              seq_wen, sn_uen, st_en;
    bus_cmd_e          seq_cmd;

    mesi_req_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_seq (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .snoop_active(snp_valid),
        .line_idx(rq_idx), .line_state(rq_state), .line_tag(rq_tag), .line_data(rq_data),
        .bus_req(bus_req), .bus_cmd(seq_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .shared_in(shared_in),
        .wr_en(seq_wen), .wr_state(seq_wstate), .wr_tag(seq_wtag), .wr_data(seq_wdata)
    );

    mesi_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .line_idx(sn_idx), .line_state(sn_state), .line_tag(sn_tag), .line_data(sn_data),
        .shared_out(shared_out), .flush_valid(flush_valid), .flush_data(flush_data),
        .upd_en(sn_uen), .upd_state(sn_ustate)
    );

    // Snoop updates win; the sequencer is held off while a snoop is present.
    always_comb begin
        if (sn_uen) begin
            st_en    = 1'b1;
            st_idx   = sn_idx;
            st_state = sn_ustate;
            st_tag   = sn_tag;
            st_data  = sn_data;
        end else begin
            st_en    = seq_wen;
            st_idx   = rq_idx;
            st_state = seq_wstate;
            st_tag   = seq_wtag;
            st_data  = seq_wdata;
        end
    end

    mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
        .clk(clk), .rst(rst),
        .wr_en(st_en), .wr_idx(st_idx), .wr_state(st_state), .wr_tag(st_tag), .wr_data(st_data),
        .a_idx(rq_idx), .a_state(rq_state), .a_tag(rq_tag), .a_data(rq_data),
        .b_idx(sn_idx), .b_state(sn_state), .b_tag(sn_tag), .b_data(sn_data)
    );

    assign bus_cmd = seq_cmd;

endmodule

// File: rtl/mesi_ctrl_chk.sv
module mesi_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       snp_valid,
    input logic [1:0] snp_cmd,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [1:0] bus_cmd,
    input logic       shared_out,
    input logic       flush_valid,
    input logic       cpu_resp_valid
);

    p_quiet_under_snoop_r11: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> !bus_req);

    p_shared_on_read_r7: assert property (@(posedge clk) disable iff (rst)
        shared_out |-> (snp_valid && snp_cmd == 2'd1));

    p_flush_on_snoop_r8: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> snp_valid);

    p_resp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |=> !cpu_resp_valid);

    p_wb_then_fill_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && bus_cmd == 2'd3) |=> !(bus_req && bus_cmd == 2'd3));

    p_real_command_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> bus_cmd != 2'd0);

endmodule

bind mesi_ctrl mesi_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .shared_out(shared_out), .flush_valid(flush_valid), .cpu_resp_valid(cpu_resp_valid)
);

// File: tb/test_mesi_ctrl.sv
`timescale 1ns/1ps
module test_mesi_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [7:0]  cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_req_ready, cpu_resp_valid;
    logic [31:0] cpu_resp_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        shared_in = 1'b0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        shared_out, flush_valid;
    logic [31:0] flush_data;

    always #2 clk = ~clk;

    mesi_ctrl i_mesi_ctrl (.*);

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // reference model: 0 I, 1 S, 2 E, 3 M
    int          r_st  [8];
    logic [4:0]  r_tag [8];
    logic [31:0] r_dat [8];
    logic [31:0] mem   [256];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          input logic shr, input string req);
        int          idx = int'(a[2:0]);
        logic [4:0]  tg = a[7:3];
        bit          match = (r_st[idx] != 0) && (r_tag[idx] == tg);
        logic [1:0]  ec [3];
        logic [7:0]  ea [3];
        logic [31:0] ed [3];
        int          en = 0, n = 0, cyc = 0;
        bit          got = 0;
        logic [31:0] rd = '0, base, exp;
        if (r_st[idx] == 3 && r_tag[idx] != tg) begin
            ec[0] = 2'd3; ea[0] = {r_tag[idx], a[2:0]}; ed[0] = r_dat[idx]; en = 1;
        end
        if (!match) begin
            ec[en] = wr ? 2'd2 : 2'd1; ea[en] = a; ed[en] = '0; en++;
        end else if (wr && r_st[idx] == 1) begin
            ec[en] = 2'd2; ea[en] = a; ed[en] = '0; en++;
        end
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
        #1 check(cpu_req_ready, "R6 ready", 32'(cpu_req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!got && cyc < 30) begin
            #1;
            if (cpu_resp_valid) begin
                got = 1; rd = cpu_resp_rdata;
            end else begin
                check(!cpu_req_ready, "R6 busy", 32'(cpu_req_ready), 0);
                if (bus_req) begin
                    check(n < en, {req, " extra bus cmd"}, 32'(bus_cmd), 0);
                    if (n < en) begin
                        check(bus_cmd == ec[n], {req, " bus cmd"}, 32'(bus_cmd), 32'(ec[n]));
                        check(bus_addr == ea[n], {req, " bus addr"}, 32'(bus_addr), 32'(ea[n]));
                        if (ec[n] == 2'd3)
                            check(bus_wdata == ed[n], "R10 wb data", bus_wdata, ed[n]);
                    end
                    bus_gnt = 1'b1; bus_rdata = mem[bus_addr]; shared_in = shr;
                    if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
                    n++;
                end
                @(posedge clk);
                @(negedge clk);
                bus_gnt = 1'b0;
                cyc++;
            end
        end
        check(got, {req, " response"}, 32'(got), 1);
        check(n == en, {req, " bus count"}, 32'(n), 32'(en));
        if (en == 0) check(cyc == 1, "R5 hit latency", 32'(cyc), 1);
        base = match ? r_dat[idx] : mem[a];
        exp  = wr ? d : base;
        check(rd == exp, {req, " data"}, rd, exp);
        r_tag[idx] = tg;
        if (wr) begin
            r_st[idx] = 3; r_dat[idx] = d;
        end else if (!match) begin
            r_st[idx] = shr ? 1 : 2; r_dat[idx] = mem[a];
        end
        @(posedge clk);
        @(negedge clk);
        #1 check(!cpu_resp_valid, "R6 pulse", 32'(cpu_resp_valid), 0);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a);
        int    idx = int'(a[2:0]);
        bit    hit = (r_st[idx] != 0) && (r_tag[idx] == a[7:3]);
        bit    xs = hit && c == 2'd1;
        bit    xf = hit && r_st[idx] == 3;
        string req = !hit ? "R9" : (c == 2'd1 ? "R7" : "R8");
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        check(shared_out == xs, {req, " shared"}, 32'(shared_out), 32'(xs));
        check(flush_valid == xf, {req, " flush"}, 32'(flush_valid), 32'(xf));
        if (xf) check(flush_data == r_dat[idx], {req, " flush data"}, flush_data, r_dat[idx]);
        check(!bus_req, "R11 idle bus", 32'(bus_req), 0);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        if (xf) mem[a] = r_dat[idx];
        if (hit) r_st[idx] = (c == 2'd1) ? 1 : 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + i * 32'h0001_0101;
        for (int i = 0; i < 8; i++) begin
            r_st[i] = 0; r_tag[i] = '0; r_dat[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(cpu_req_ready, "R1 ready", 32'(cpu_req_ready), 1);
        check(!cpu_resp_valid, "R1 resp", 32'(cpu_resp_valid), 0);
        check(!bus_req, "R1 bus", 32'(bus_req), 0);

        cpu_op(0, 8'h05, 0, 0, "R1");
        cpu_op(0, 8'h0A, 0, 0, "R2");
        cpu_op(0, 8'h0A, 0, 1, "R5");
        cpu_op(1, 8'h0A, 32'hCAFE_0001, 0, "R3");
        cpu_op(1, 8'h0A, 32'hCAFE_0002, 0, "R5");
        cpu_op(0, 8'h13, 0, 1, "R2");
        cpu_op(1, 8'h13, 32'hBEEF_0003, 0, "R4");
        snoop(2'd1, 8'h0A);
        snoop(2'd1, 8'h05);
        snoop(2'd2, 8'h13);
        snoop(2'd2, 8'h05);
        snoop(2'd1, 8'h6A);
        snoop(2'd2, 8'h0B);
        cpu_op(1, 8'h21, 32'hD00D_0004, 0, "R4");
        cpu_op(0, 8'h29, 0, 0, "R10");
        cpu_op(0, 8'h31, 0, 1, "R10");
        cpu_op(0, 8'h0A, 0, 0, "R6");

        // R11: snoop while a write miss is offered a grant
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h42;
        cpu_req_wdata = 32'h5A5A_0011;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        #1 check(bus_req && bus_cmd == 2'd2, "R4 upgrade", 32'(bus_cmd), 2);
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h77; bus_gnt = 1'b1;
        #1 check(!bus_req, "R11 held", 32'(bus_req), 0);
        check(!shared_out, "R9 miss", 32'(shared_out), 0);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0; bus_gnt = 1'b0;
        #1 check(bus_req && bus_cmd == 2'd2, "R11 resumed", 32'(bus_cmd), 2);
        bus_gnt = 1'b1; bus_rdata = mem[8'h42]; shared_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        bus_gnt = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1 check(cpu_resp_valid && cpu_resp_rdata == 32'h5A5A_0011, "R11 resp",
                 cpu_resp_rdata, 32'h5A5A_0011);
        r_st[2] = 3; r_tag[2] = 5'h08; r_dat[2] = 32'h5A5A_0011;
        @(posedge clk);

        for (int it = 0; it < 400; it++) begin
            logic [31:0] r;
            logic [7:0]  a;
            r = $urandom;
            a = {3'b000, r[1:0], r[4:2]};
            if (r[8:7] == 2'd3)
                snoop(r[9] ? 2'd2 : 2'd1, a);
            else
                cpu_op(r[10], a, $urandom, r[11], r[10] ? "R4" : "R2");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule